// File: doc/BRIEF.md
# Banked Integer Register File

This block holds the integer registers of a 64-bit core. It has two combinational read ports and one write port that commits on the rising clock edge. A single privileged-mode input, `priv_i`, changes where some register numbers point. While it is high, register numbers 8 to 14 and register 25 use a private eight-entry shadow bank. The normal copies of those registers keep their values. Privileged code can therefore use those registers freely without saving the interrupted context first.

Each access goes through one of three routes:
- `ROUTE_MAIN` selects the 31-entry normal array.
- `ROUTE_SHADOW` selects the 8-entry shadow bank.
- `ROUTE_ZERO` selects the hardwired zero register.

The route is computed again for every port in every cycle from that port's register number and the current `priv_i`. There is no held mode state. A change of `priv_i` therefore moves the route from `ROUTE_MAIN` to `ROUTE_SHADOW`, or back, on the very next access. Reset clears every stored entry.

Top module: `rf_banked_top`

## Requirements
- R1: While `rst_n` is low, every entry of both the normal array and the shadow bank is cleared. After reset, every register number reads 0 in either mode.
- R2: With `priv_i` low, register numbers 0 to 30 each address their own normal entry. A write to one of them is read back from the next cycle on.
- R3: With `priv_i` high, register numbers 8 to 14 address shadow entries 0 to 6 for both reads and writes. The normal copies of registers 8 to 14 are left unchanged.
- R4: With `priv_i` high, register number 25 addresses shadow entry 7 for both reads and writes. The normal copy of register 25 is left unchanged.
- R5: With `priv_i` high, every register number other than 8 to 14, 25 and 31 addresses the same normal entry that it addresses with `priv_i` low.
- R6: Register number 31 always reads 0 in either mode, and writes to it are discarded.
- R7: A read of the entry being written in the same cycle returns the value held before the write. The new value is visible from the next cycle on.
- R8: The route is taken from `priv_i` in the same cycle as each access. Toggling `priv_i` from one cycle to the next alternates a banked register number between its shadow and normal copies with no delay.
- R9: The two read ports are independent. Each port returns the entry that its own address selects in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset that clears all entries |
| priv_i | input | 1 | Privileged-mode flag that selects the shadow routing |
| rd_addr_a | input | 5 | Register number for read port A |
| rd_data_a | output | 64 | Combinational read data for port A |
| rd_addr_b | input | 5 | Register number for read port B |
| rd_data_b | output | 64 | Combinational read data for port B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Register number to write |
| wr_data | input | 64 | Write data |

## Verification
Two functions can fall in the same cycle:
- A write and a read that resolve to the same entry.
- A change of `priv_i` and an access to a banked register number.

The bench provokes the first by writing and reading one register number in one cycle, in both routes. It judges the result by expecting the old value in that cycle and the new value in the next. It provokes the second by toggling `priv_i` on every cycle while both ports read registers 9 and 25. Different values have already been stored in the shadow and normal copies, so a stale route shows up as a wrong value.

// File: rtl/rf_bank_pkg.sv
package rf_bank_pkg;

    // Where one register access resolves to.
    typedef enum logic [1:0] {
        ROUTE_MAIN   = 2'd0,
        ROUTE_SHADOW = 2'd1,
        ROUTE_ZERO   = 2'd2
    } route_e;

endpackage

// File: rtl/rf_bank_map.sv
module rf_bank_map
    import rf_bank_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int SH_IW    = 3,
    parameter int SH_LO    = 8,
    parameter int SH_HI    = 14,
    parameter int SH_EXTRA = 25,
    parameter int ZERO_REG = 31
) (
    input  logic              priv_i,
    input  logic [ADDR_W-1:0] addr_i,
    output route_e            route_o,
    output logic [SH_IW-1:0]  sh_idx_o
);

    // The extra banked register takes the slot just after the contiguous run.
    localparam int EXTRA_SLOT = SH_HI - SH_LO + 1;

    always_comb begin
        route_o  = ROUTE_MAIN;
        sh_idx_o = '0;
        if (addr_i == ADDR_W'(ZERO_REG)) begin
            route_o = ROUTE_ZERO;
        end else if (priv_i && (addr_i >= ADDR_W'(SH_LO)) && (addr_i <= ADDR_W'(SH_HI))) begin
            route_o  = ROUTE_SHADOW;
            sh_idx_o = SH_IW'(addr_i - ADDR_W'(SH_LO));
        end else if (priv_i && (addr_i == ADDR_W'(SH_EXTRA))) begin
            route_o  = ROUTE_SHADOW;
            sh_idx_o = SH_IW'(EXTRA_SLOT);
        end
    end

endmodule

// File: rtl/rf_store.sv
module rf_store #(
    parameter int DEPTH  = 31,
    parameter int IDX_W  = 5,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  ridx_a_i,
    input  logic [IDX_W-1:0]  ridx_b_i,
    output logic [DATA_W-1:0] rdata_a_o,
    output logic [DATA_W-1:0] rdata_b_o
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we_i) begin
            mem[widx_i] <= wdata_i;
        end
    end

    // Asynchronous reads see the pre-edge contents during a write cycle.
    assign rdata_a_o = mem[ridx_a_i];
    assign rdata_b_o = mem[ridx_b_i];

endmodule

// File: rtl/rf_banked_top.sv
module rf_banked_top
    import rf_bank_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 32,
    parameter int SH_DEPTH = 8,
    parameter int SH_LO    = 8,
    parameter int SH_HI    = 14,
    parameter int SH_EXTRA = 25
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        priv_i,
    input  logic [$clog2(NUM_REGS)-1:0] rd_addr_a,
    output logic [DATA_W-1:0]           rd_data_a,
    input  logic [$clog2(NUM_REGS)-1:0] rd_addr_b,
    output logic [DATA_W-1:0]           rd_data_b,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_REGS)-1:0] wr_addr,
    input  logic [DATA_W-1:0]           wr_data
);

    localparam int ADDR_W     = $clog2(NUM_REGS);
    localparam int SH_IW      = $clog2(SH_DEPTH);
    localparam int MAIN_DEPTH = NUM_REGS - 1;
    localparam int ZERO_REG   = NUM_REGS - 1;
    localparam int NPORT      = 3; // read A, read B, write

    logic [ADDR_W-1:0] port_addr  [NPORT];
    route_e            port_route [NPORT];
    logic [SH_IW-1:0]  port_sh    [NPORT];

    assign port_addr[0] = rd_addr_a;
    assign port_addr[1] = rd_addr_b;
    assign port_addr[2] = wr_addr;

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        rf_bank_map #(
            .ADDR_W  (ADDR_W),
            .SH_IW   (SH_IW),
            .SH_LO   (SH_LO),
            .SH_HI   (SH_HI),
            .SH_EXTRA(SH_EXTRA),
            .ZERO_REG(ZERO_REG)
        ) u_map (
            .priv_i  (priv_i),
            .addr_i  (port_addr[p]),
            .route_o (port_route[p]),
            .sh_idx_o(port_sh[p])
        );
    end

    logic              main_we, sh_we;
    logic [DATA_W-1:0] main_rd [2];
    logic [DATA_W-1:0] sh_rd   [2];
    logic [DATA_W-1:0] port_rd [2];

    assign main_we = wr_en && (port_route[2] == ROUTE_MAIN);
    assign sh_we   = wr_en && (port_route[2] == ROUTE_SHADOW);

    rf_store #(
        .DEPTH (MAIN_DEPTH),
        .IDX_W (ADDR_W),
        .DATA_W(DATA_W)
    ) u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (main_we),
        .widx_i   (wr_addr),
        .wdata_i  (wr_data),
        .ridx_a_i (rd_addr_a),
        .ridx_b_i (rd_addr_b),
        .rdata_a_o(main_rd[0]),
        .rdata_b_o(main_rd[1])
    );

    rf_store #(
        .DEPTH (SH_DEPTH),
        .IDX_W (SH_IW),
        .DATA_W(DATA_W)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (sh_we),
        .widx_i   (port_sh[2]),
        .wdata_i  (wr_data),
        .ridx_a_i (port_sh[0]),
        .ridx_b_i (port_sh[1]),
        .rdata_a_o(sh_rd[0]),
        .rdata_b_o(sh_rd[1])
    );

    for (genvar r = 0; r < 2; r++) begin : g_rd
        always_comb begin
            unique case (port_route[r])
                ROUTE_MAIN:   port_rd[r] = main_rd[r];
                ROUTE_SHADOW: port_rd[r] = sh_rd[r];
                ROUTE_ZERO:   port_rd[r] = '0;
                default:      port_rd[r] = '0;
            endcase
        end
    end

    assign rd_data_a = port_rd[0];
    assign rd_data_b = port_rd[1];

endmodule

// File: rtl/rf_banked_chk.sv
module rf_banked_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        priv_i,
    input logic [4:0]  rd_addr_a,
    input logic [63:0] rd_data_a,
    input logic [4:0]  rd_addr_b,
    input logic [63:0] rd_data_b,
    input logic        wr_en,
    input logic [4:0]  wr_addr,
    input logic [63:0] wr_data
);

    // R6
    zero_read_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a == 5'd31) |-> (rd_data_a == 64'd0));

    // R6
    zero_read_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_b == 5'd31) |-> (rd_data_b == 64'd0));

    // R7
    write_visible_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && ($past(wr_addr) != 5'd31) && (rd_addr_a == $past(wr_addr))
         && (priv_i == $past(priv_i))) |-> (rd_data_a == $past(wr_data)));

    // R9
    hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en) && ($past(rd_addr_b) == rd_addr_b)
         && ($past(priv_i) == priv_i)) |-> $stable(rd_data_b));

endmodule

bind rf_banked_top rf_banked_chk u_chk (.*);

// File: tb/rf_banked_top_tb.sv
module rf_banked_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        priv_i = 1'b0;
    logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic        wr_en = 1'b0;
    logic [63:0] rd_data_a, rd_data_b;

    always #10 clk = ~clk; // 50 MHz

    rf_banked_top u_dut (
        .clk(clk), .rst_n(rst_n), .priv_i(priv_i),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [63:0] m_main [31];
    logic [63:0] m_sh [8];

    logic [63:0] q_a [$];
    logic [63:0] q_b [$];
    string       q_tag [$];

    function automatic logic [63:0] model_rd(input logic p, input logic [4:0] a);
        if (a == 5'd31) return 64'd0;
        if (p && a >= 5'd8 && a <= 5'd14) return m_sh[a - 5'd8];
        if (p && a == 5'd25) return m_sh[7];
        return m_main[a];
    endfunction

    function automatic void model_wr(input logic p, input logic [4:0] a, input logic [63:0] d);
        if (a == 5'd31) return;
        if (p && a >= 5'd8 && a <= 5'd14) m_sh[a - 5'd8] = d;
        else if (p && a == 5'd25) m_sh[7] = d;
        else m_main[a] = d;
    endfunction

    function automatic logic [63:0] pat(input int a, input int salt);
        return (64'h0101_0101_0101_0101 * (a + 1)) ^ {32'(salt), 32'h5A5A_0000 + 32'(a)};
    endfunction

    // Driver: applies one cycle and queues the expected read data.
    task automatic step(input logic p, input logic [4:0] ra, input logic [4:0] rb,
                        input logic we, input logic [4:0] wa, input logic [63:0] wd,
                        input string tag);
        @(negedge clk);
        priv_i = p; rd_addr_a = ra; rd_addr_b = rb;
        wr_en = we; wr_addr = wa; wr_data = wd;
        q_a.push_back(model_rd(p, ra));
        q_b.push_back(model_rd(p, rb));
        q_tag.push_back(tag);
        if (we) model_wr(p, wa, wd);
    endtask

    task automatic rd(input logic p, input logic [4:0] ra, input logic [4:0] rb, input string tag);
        step(p, ra, rb, 1'b0, 5'd0, 64'd0, tag);
    endtask

    // Monitor: compares mid-cycle, well before the next rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (q_a.size() > 0) begin
                logic [63:0] ea, eb;
                string t;
                ea = q_a.pop_front();
                eb = q_b.pop_front();
                t  = q_tag.pop_front();
                checks++;
                if (rd_data_a !== ea) begin
                    failures++;
                    $display("FAIL %s port A addr=%0d got=%h exp=%h", t, rd_addr_a, rd_data_a, ea);
                end
                checks++;
                if (rd_data_b !== eb) begin
                    failures++;
                    $display("FAIL %s port B addr=%0d got=%h exp=%h", t, rd_addr_b, rd_data_b, eb);
                end
            end
        end
    end

    initial begin
        #4_000_000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 31; i++) m_main[i] = '0;
        for (int i = 0; i < 8; i++) m_sh[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: everything reads zero after reset, in both modes
        for (int i = 0; i < 32; i++) begin
            rd(1'b0, 5'(i), 5'(31 - i), "R1");
            rd(1'b1, 5'(i), 5'(31 - i), "R1");
        end

        // R2: unprivileged write of every register, then read back
        for (int i = 0; i < 31; i++)
            step(1'b0, 5'd0, 5'd1, 1'b1, 5'(i), pat(i, 1), "R2");
        for (int i = 0; i < 31; i++)
            rd(1'b0, 5'(i), 5'(30 - i), "R2");

        // R3 / R4: privileged writes land in the shadow bank
        for (int i = 8; i <= 14; i++)
            step(1'b1, 5'd0, 5'd0, 1'b1, 5'(i), pat(i, 77), "R3");
        step(1'b1, 5'd0, 5'd0, 1'b1, 5'd25, pat(25, 77), "R4");
        for (int i = 8; i <= 14; i++)
            rd(1'b1, 5'(i), 5'd25, "R3");
        rd(1'b1, 5'd25, 5'd8, "R4");
        // normal copies untouched
        for (int i = 8; i <= 14; i++)
            rd(1'b0, 5'(i), 5'd25, "R3");
        rd(1'b0, 5'd25, 5'd14, "R4");

        // R5: privileged mode shares the non-banked registers
        for (int i = 0; i < 31; i++)
            rd(1'b1, 5'(i), 5'(i), "R5");
        step(1'b1, 5'd0, 5'd0, 1'b1, 5'd3, pat(3, 9), "R5");
        step(1'b1, 5'd0, 5'd0, 1'b1, 5'd15, pat(15, 9), "R5");
        step(1'b1, 5'd0, 5'd0, 1'b1, 5'd24, pat(24, 9), "R5");
        rd(1'b0, 5'd3, 5'd15, "R5");
        rd(1'b0, 5'd24, 5'd7, "R5");

        // R6: register 31 ignores writes in both modes
        step(1'b0, 5'd31, 5'd31, 1'b1, 5'd31, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
        rd(1'b0, 5'd31, 5'd31, "R6");
        step(1'b1, 5'd31, 5'd31, 1'b1, 5'd31, 64'hDEAD_BEEF_0000_0001, "R6");
        rd(1'b1, 5'd31, 5'd30, "R6");
        rd(1'b0, 5'd30, 5'd31, "R6");

        // R7: same-cycle write and read return the old value, new one next cycle
        step(1'b0, 5'd5, 5'd5, 1'b1, 5'd5, pat(5, 300), "R7");
        rd(1'b0, 5'd5, 5'd4, "R7");
        step(1'b1, 5'd10, 5'd25, 1'b1, 5'd10, pat(10, 301), "R7");
        step(1'b1, 5'd10, 5'd25, 1'b1, 5'd25, pat(25, 302), "R7");
        rd(1'b1, 5'd10, 5'd25, "R7");
        rd(1'b0, 5'd10, 5'd25, "R7");

        // R8: toggle the mode every cycle on banked registers
        for (int k = 0; k < 8; k++)
            rd(k[0], 5'd9, 5'd25, "R8");
        // write in one mode, immediately read the same number in the other
        step(1'b1, 5'd9, 5'd9, 1'b1, 5'd9, pat(9, 400), "R8");
        rd(1'b0, 5'd9, 5'd9, "R8");
        step(1'b0, 5'd9, 5'd9, 1'b1, 5'd9, pat(9, 401), "R8");
        rd(1'b1, 5'd9, 5'd9, "R8");
        rd(1'b0, 5'd9, 5'd9, "R8");

        // R9: independent port addresses across both routes
        for (int i = 0; i < 32; i++)
            rd(i[1], 5'(i), 5'((i * 7 + 3) % 32), "R9");

        rd(1'b0, 5'd0, 5'd0, "R9");
        repeat (2) @(negedge clk);
        #6;
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule